// File: doc/BRIEF.md
# Interleaved-Bus Two-Channel Pair Receiver

This block sits on the host side of a shared word bus that carries two sample channels by turns. It runs from a capture clock at twice the sample rate, so each capture cycle presents one word. A side line says which channel the word belongs to: high for channel A, low for channel B. The B word of a sampling instant arrives one capture cycle after the A word of the same instant. The receiver sorts the words by the side line, keeps each A word until its B partner arrives, and then emits both as one aligned pair with a one-cycle strobe. This suits in-phase/quadrature baseband streams, where the two halves of a sample must never slip against each other.

The bus may use offset-binary coding (mid-scale 10'b10_0000_0000) or two's complement (mid-scale 10'b00_0000_0000). On request, offset-binary words are turned into signed values by inverting the MSB, so both outputs become signed 10-bit numbers. The receiver also watches the order of the words. A B word with no A word waiting is dropped and counted. Two accepted words in a row with the same channel flag set a sticky fault. A word that repeats the last accepted word exactly, with the same flag, is taken to be a stalled bus and is ignored. An enable input stops all capture.

Top module: `ilv_pair_rx`

## Requirements
- R1: After reset, pair_valid, seq_fault, orphan_count, pair_a and pair_b are all zero.
- R2: When an accepted word with bus_is_a=1 is followed by an accepted word with bus_is_a=0, pair_valid is high in the cycle after the B word is sampled. pair_a then carries the held A word and pair_b carries the B word.
- R3: An accepted B word (bus_is_a=0) with no A word held emits no pair and raises orphan_count by one. The count saturates at its all-ones value.
- R4: Two accepted words in a row with the same bus_is_a value set seq_fault. It stays set until reset.
- R5: An A word followed by another, different A word replaces the held A word. The next pair uses the newer one.
- R6: A word equal in value and in bus_is_a to the previous accepted word is ignored. It makes no pair, no count step, no fault and no change of the held state.
- R7: While en=0, bus words are not sampled. No pair is emitted and no state changes.
- R8: With fmt_twos=0 (offset binary) and want_signed=1, bit 9 of both pair_a and pair_b is inverted relative to the bus words. For example, mid-scale 10'h200 comes out as 10'h000.
- R9: With fmt_twos=1, or with want_signed=0, pair_a and pair_b equal the bus words unchanged.
- R10: pair_valid is high for one cycle only per pair. pair_a and pair_b hold their last values between pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Capture enable |
| fmt_twos | input | 1 | Bus coding: 1 two's complement, 0 offset binary |
| want_signed | input | 1 | Request signed output values |
| bus_word | input | 10 | Shared data word, bit 9 is the MSB |
| bus_is_a | input | 1 | Channel flag: 1 channel A, 0 channel B |
| pair_valid | output | 1 | One-cycle strobe for a new pair |
| pair_a | output | 10 | Channel A word of the pair |
| pair_b | output | 10 | Channel B word of the pair |
| seq_fault | output | 1 | Sticky order fault |
| orphan_count | output | 8 | Saturating count of dropped B words |

## Verification
The bench goes after order faults: B before any A, A-A replacement, and B-B runs. A receiver that pairs a B word with a stale A word would emit pairs that the model does not expect. One that never clears its held A would show up the same way. A stalled bus that repeats one word is fed in both with and without the enable. A design that treats a repeat as fresh data would raise the fault or step the count. Runs of more than 255 orphan B words check that the counter saturates rather than wraps. Mid-scale and full-scale words go through every coding and sign setting, so a wrong MSB handling shows as a data mismatch.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic {
    CODE_OFFSET = 1'b0,
    CODE_TWOS   = 1'b1
  } code_e;

  // MSB inversion turns offset-binary into signed; two's complement is already signed
  function automatic logic need_msb_flip(code_e coding, logic signed_req);
    return signed_req && (coding == CODE_OFFSET);
  endfunction

endpackage

// File: rtl/ilv_rst_sync.sv
module ilv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ilv_word_sorter.sv
module ilv_word_sorter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] word,
  input  logic         is_a,
  output logic         pair_fire,
  output logic [W-1:0] a_word,
  output logic         orphan_hit,
  output logic         order_hit
);
  logic         have_a_q, have_a_d;
  logic [W-1:0] a_hold_q, a_hold_d;
  logic         last_vld_q, last_vld_d;
  logic [W-1:0] last_word_q, last_word_d;
  logic         last_ind_q, last_ind_d;
  logic         stalled, accept;

  always_comb begin
    stalled    = last_vld_q && (word == last_word_q) && (is_a == last_ind_q);
    accept     = en && !stalled;
    order_hit  = accept && last_vld_q && (is_a == last_ind_q);
    pair_fire  = accept && !is_a && have_a_q;
    orphan_hit = accept && !is_a && !have_a_q;

    have_a_d    = have_a_q;
    a_hold_d    = a_hold_q;
    last_vld_d  = last_vld_q;
    last_word_d = last_word_q;
    last_ind_d  = last_ind_q;
    if (accept) begin
      last_vld_d  = 1'b1;
      last_word_d = word;
      last_ind_d  = is_a;
      if (is_a) begin
        have_a_d = 1'b1;
        a_hold_d = word;
      end else begin
        have_a_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_a_q    <= 1'b0;
      a_hold_q    <= '0;
      last_vld_q  <= 1'b0;
      last_word_q <= '0;
      last_ind_q  <= 1'b0;
    end else begin
      have_a_q    <= have_a_d;
      a_hold_q    <= a_hold_d;
      last_vld_q  <= last_vld_d;
      last_word_q <= last_word_d;
      last_ind_q  <= last_ind_d;
    end
  end

  assign a_word = a_hold_q;
endmodule

// File: rtl/ilv_code_conv.sv
module ilv_code_conv #(
  parameter int W     = 10,
  parameter int LANES = 2
) (
  input  ilv_pkg::code_e       coding,
  input  logic                 signed_req,
  input  logic [LANES*W-1:0]   din,
  output logic [LANES*W-1:0]   dout
);
  logic flip;
  assign flip = ilv_pkg::need_msb_flip(coding, signed_req);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*W +: W-1] = din[g*W +: W-1];
    assign dout[g*W + W-1]  = din[g*W + W-1] ^ flip;
  end
endmodule

// File: rtl/ilv_sat_counter.sv
module ilv_sat_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && (cnt_q != CMAX)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/ilv_pair_rx.sv
module ilv_pair_rx #(
  parameter int W       = 10,
  parameter int CNT_W   = 8,
  parameter int RST_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fmt_twos,
  input  logic             want_signed,
  input  logic [W-1:0]     bus_word,
  input  logic             bus_is_a,
  output logic             pair_valid,
  output logic [W-1:0]     pair_a,
  output logic [W-1:0]     pair_b,
  output logic             seq_fault,
  output logic [CNT_W-1:0] orphan_count
);
  localparam int LANES = 2;

  logic           rst_i_n;
  logic           fire, orphan_hit, order_hit;
  logic [W-1:0]   a_word;
  logic [LANES*W-1:0] raw_pair, conv_pair;
  ilv_pkg::code_e coding;

  logic           pv_q, pv_d;
  logic [W-1:0]   pa_q, pa_d, pb_q, pb_d;
  logic           flt_q, flt_d;

  ilv_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  ilv_word_sorter #(.W(W)) u_sort (
    .clk(clk), .rst_n(rst_i_n), .en(en), .word(bus_word), .is_a(bus_is_a),
    .pair_fire(fire), .a_word(a_word), .orphan_hit(orphan_hit), .order_hit(order_hit)
  );

  assign coding   = fmt_twos ? ilv_pkg::CODE_TWOS : ilv_pkg::CODE_OFFSET;
  assign raw_pair = {bus_word, a_word};

  ilv_code_conv #(.W(W), .LANES(LANES)) u_conv (
    .coding(coding), .signed_req(want_signed), .din(raw_pair), .dout(conv_pair)
  );

  ilv_sat_counter #(.CW(CNT_W)) u_orph (
    .clk(clk), .rst_n(rst_i_n), .inc(orphan_hit), .count(orphan_count)
  );

  always_comb begin
    pv_d  = fire;
    pa_d  = pa_q;
    pb_d  = pb_q;
    flt_d = flt_q | order_hit;
    if (fire) begin
      pa_d = conv_pair[0 +: W];
      pb_d = conv_pair[W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pv_q  <= 1'b0;
      pa_q  <= '0;
      pb_q  <= '0;
      flt_q <= 1'b0;
    end else begin
      pv_q  <= pv_d;
      pa_q  <= pa_d;
      pb_q  <= pb_d;
      flt_q <= flt_d;
    end
  end

  assign pair_valid = pv_q;
  assign pair_a     = pa_q;
  assign pair_b     = pb_q;
  assign seq_fault  = flt_q;
endmodule

// File: rtl/ilv_pair_rx_chk.sv
module ilv_pair_rx_chk #(
  parameter int W     = 10,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             bus_is_a,
  input logic             pair_valid,
  input logic             seq_fault,
  input logic [CNT_W-1:0] orphan_count
);
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fault |=> seq_fault); // R4

  AST_PAIR_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> ($past(en) && !$past(bus_is_a))); // R2

  AST_IDLE_NO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pair_valid); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid); // R10

  AST_ORPHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (orphan_count != $past(orphan_count)) |->
      (orphan_count == CNT_W'($past(orphan_count) + 1'b1))); // R3
endmodule

bind ilv_pair_rx ilv_pair_rx_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bus_is_a(bus_is_a),
  .pair_valid(pair_valid), .seq_fault(seq_fault), .orphan_count(orphan_count)
);

// File: tb/test_ilv_pair_rx.sv
module test_ilv_pair_rx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, fmt_twos, want_signed, bus_is_a;
  logic [9:0] bus_word;
  logic       pair_valid, seq_fault;
  logic [9:0] pair_a, pair_b;
  logic [7:0] orphan_count;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  ilv_pair_rx i_ilv_pair_rx (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt_twos(fmt_twos), .want_signed(want_signed),
    .bus_word(bus_word), .bus_is_a(bus_is_a), .pair_valid(pair_valid),
    .pair_a(pair_a), .pair_b(pair_b), .seq_fault(seq_fault), .orphan_count(orphan_count)
  );

  // behavioural reference model
  bit     m_have_a, m_last_vld, m_last_ind, m_seq, m_pv;
  int     m_ahold, m_last_word, m_orph, m_pa, m_pb;

  function automatic int conv(int w);
    if (want_signed && !fmt_twos) return w ^ 'h200;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_have_a = 0; m_last_vld = 0; m_last_ind = 0; m_seq = 0; m_pv = 0;
      m_ahold = 0; m_last_word = 0; m_orph = 0; m_pa = 0; m_pb = 0;
    end else begin
      m_pv = 0;
      if (en && !(m_last_vld && int'(bus_word) == m_last_word && bus_is_a == m_last_ind)) begin
        if (m_last_vld && bus_is_a == m_last_ind) m_seq = 1;
        if (bus_is_a) begin
          m_ahold = bus_word; m_have_a = 1;
        end else if (m_have_a) begin
          m_pv = 1; m_pa = conv(m_ahold); m_pb = conv(bus_word); m_have_a = 0;
        end else if (m_orph < 255) m_orph++;
        m_last_vld = 1; m_last_word = bus_word; m_last_ind = bus_is_a;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 R10 pair_valid", pair_valid, m_pv);
    check((want_signed && !fmt_twos) ? "R8 pair_a" : "R9 pair_a", pair_a, m_pa);
    check((want_signed && !fmt_twos) ? "R8 pair_b" : "R9 pair_b", pair_b, m_pb);
    check("R4 seq_fault", seq_fault, m_seq);
    check("R3 orphan_count", orphan_count, m_orph);
  endtask

  task automatic step(bit e, bit ind, logic [9:0] w);
    @(negedge clk);
    en = e; bus_is_a = ind; bus_word = w;
    @(posedge clk); #1;
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; en = 0; bus_is_a = 0; bus_word = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) begin @(posedge clk); #1; compare_all(); end
  endtask

  initial begin
    fmt_twos = 1; want_signed = 0;
    do_reset();
    // R1 reset state
    check("R1 valid", pair_valid, 0);
    check("R1 fault", seq_fault, 0);
    check("R1 count", orphan_count, 0);
    check("R1 data", {pair_a, pair_b}, 0);

    // R2 basic pairs, R9 pass-through
    step(1, 1, 10'h155); step(1, 0, 10'h0AA);
    check("R2 valid", pair_valid, 1);
    check("R2 a", pair_a, 'h155);
    check("R9 b", pair_b, 'h0AA);
    step(1, 1, 10'h3FF);
    check("R10 single pulse", pair_valid, 0);
    check("R10 hold a", pair_a, 'h155);
    step(1, 0, 10'h001);

    // R8 offset binary signed: mid-scale -> 0
    fmt_twos = 0; want_signed = 1;
    step(1, 1, 10'h200); step(1, 0, 10'h3FF);
    check("R8 a mid", pair_a, 'h000);
    check("R8 b full", pair_b, 'h1FF);
    want_signed = 0;
    step(1, 1, 10'h200); step(1, 0, 10'h000);
    check("R9 a unchanged", pair_a, 'h200);
    fmt_twos = 1; want_signed = 1;
    step(1, 1, 10'h2AB); step(1, 0, 10'h123);
    check("R9 twos signed", pair_a, 'h2AB);

    // R7 disable: no pair, nothing captured
    step(0, 1, 10'h011); step(0, 0, 10'h022);
    check("R7 no pair", pair_valid, 0);
    check("R7 no fault", seq_fault, 0);

    // R6 stalled bus: identical A repeated, then B pairs
    step(1, 1, 10'h0F0); step(1, 1, 10'h0F0); step(1, 1, 10'h0F0);
    check("R6 no fault", seq_fault, 0);
    step(1, 0, 10'h00F);
    check("R6 pair", pair_valid, 1);
    step(1, 0, 10'h00F);
    check("R6 repeat B ignored count", orphan_count, 0);

    // R5 A replaced, sets fault (R4)
    step(1, 1, 10'h111); step(1, 1, 10'h222); step(1, 0, 10'h333);
    check("R5 newest a", pair_a, 'h222);
    check("R4 fault set", seq_fault, 1);

    // R3 orphan B words and saturation
    do_reset();
    step(1, 0, 10'h050);
    check("R3 first orphan", orphan_count, 1);
    check("R3 no pair", pair_valid, 0);
    for (int k = 0; k < 300; k++) step(1, 0, 10'(k + 1));
    check("R3 saturated", orphan_count, 255);
    check("R4 fault sticky", seq_fault, 1);

    // mixed pattern
    do_reset();
    for (int k = 0; k < 400; k++) begin
      fmt_twos = k[3]; want_signed = k[4];
      step(k % 7 != 3, (k % 5 == 2) ? k[1] : !k[0], 10'((k * 37) ^ (k >> 2)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule